// File: doc/BRIEF.md
# Sparse Ternary Cyclic Convolution Engine

This block multiplies a dense polynomial by a sparse ternary polynomial in the ring Z_q[x]/(x^N - 1) with q = 2048. The dense operand holds N coefficients of 11 bits each. It is written one coefficient at a time through a load port while the engine is idle. The ternary operand is never stored as a whole. Each of its nonzero terms arrives as a position and a sign over a small term port. The engine asks for a new term by pulsing a take strobe. In encryption the dense operand is the public key and the ternary operand is the blinding polynomial. In decryption they are the ciphertext and the private key.

A term at position k cyclically rotates the dense polynomial by k places, so coefficient i moves to slot (i + k) mod N. The engine then adds the rotated copy to all N accumulator lanes at once, or subtracts it, with wraparound modulo 2048. Each term costs exactly three cycles: capture, rotate, accumulate. A multiplication with d terms of each sign therefore takes 3·2d cycles whatever N is. The caller normally supplies the +1 terms first and the -1 terms after them, but only the sign bit decides the operation. The flat result vector holds its value from the done pulse until the next accepted start.

Top module: `tern_conv_mul`

## Requirements
- R1: While busy is low, a load with load_addr below N writes load_data into dense coefficient load_addr. A load while busy is high, or a load with load_addr of N or more, leaves the dense operand unchanged.
- R2: A start seen while busy is low clears every result coefficient to zero at that clock edge and raises busy.
- R3: term_take is high for exactly one cycle per term. The first term_take comes in the cycle after the start edge, and further ones follow every third cycle until 2·D terms have been taken. term_idx and term_neg are sampled at the edge that ends each term_take cycle.
- R4: A term with term_neg = 0 and index k adds dense coefficient i into result coefficient (i + k) mod N for every i, modulo 2048.
- R5: A term with term_neg = 1 subtracts in the same way, modulo 2048. The sign bit alone selects the operation, whatever the position of the term in the sequence.
- R6: done is a single-cycle pulse. It is high in the cycle after the 6·D-th rising edge that follows the edge sampling start. busy falls at that same edge.
- R7: Between the done pulse and the next accepted start, the result does not change. A start while busy is ignored.
- R8: Coefficients wrap modulo 2048. For example, dense coefficients of 2047 added by several terms give the truncated sum.
- R9: Term indices 0 (no rotation) and N-1 (rotation by one slot toward index 0) rotate correctly. Indices must be below N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Write strobe for one dense coefficient |
| load_addr | input | $clog2(N) | Dense coefficient index |
| load_data | input | 11 | Dense coefficient value |
| start | input | 1 | Begin a multiplication and clear the result |
| term_idx | input | $clog2(N) | Position of the current ternary term |
| term_neg | input | 1 | 1 for a -1 term, 0 for a +1 term |
| term_take | output | 1 | Term fields are captured at the end of this cycle |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | N·11 | Result coefficients, coefficient j at bits [11j+10:11j] |

## Verification
The convolution is tried with a mixed pattern of scattered indices and both signs. It is also tried with index 0 and index N-1 alone, which separates a missing rotation from a rotation in the wrong direction. A third case uses all-2047 dense coefficients and four positive terms, which exposes any carry kept past bit 10. A fourth case uses all-negative terms given in a mixed order, which shows whether the sign bit or the term's position drives subtraction. Further cases load and start during a run and observe the next result, and check that the cycle count and result hold after done.

// File: rtl/tern_conv_pkg.sv
package tern_conv_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GRAB  = 2'd1,
      ST_TURN  = 2'd2,
      ST_APPLY = 2'd3
   } conv_state_e;
endpackage

// File: rtl/tern_conv_ctrl.sv
module tern_conv_ctrl
   import tern_conv_pkg::*;
#(
   parameter int D = 63
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic clr,
   output logic grab_en,
   output logic turn_en,
   output logic apply_en,
   output logic busy,
   output logic done
);
   localparam int NTERMS = 2 * D;
   localparam int CNTW   = $clog2(NTERMS + 1);
   localparam logic [CNTW-1:0] LAST = CNTW'(NTERMS - 1);

   conv_state_e state_q;
   logic [CNTW-1:0] cnt_q;

   assign busy     = (state_q != ST_IDLE);
   assign clr      = start && !busy;
   assign grab_en  = (state_q == ST_GRAB);
   assign turn_en  = (state_q == ST_TURN);
   assign apply_en = (state_q == ST_APPLY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               state_q <= ST_GRAB;
               cnt_q   <= '0;
            end
            ST_GRAB:  state_q <= ST_TURN;
            ST_TURN:  state_q <= ST_APPLY;
            ST_APPLY: begin
               if (cnt_q == LAST) begin
                  state_q <= ST_IDLE;
                  done    <= 1'b1;
               end else begin
                  state_q <= ST_GRAB;
                  cnt_q   <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tern_conv_rotator.sv
module tern_conv_rotator #(
   parameter int N  = 1087,
   parameter int CW = 11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 turn_en,
   input  logic [$clog2(N)-1:0] shift,
   input  logic [N*CW-1:0]      dense,
   output logic [N*CW-1:0]      rotated
);
   localparam int IW = $clog2(N);

   for (genvar j = 0; j < N; j++) begin : g_lane
      logic [CW-1:0] pick;
      always_comb begin
         int k;
         int src;
         k    = int'(shift);
         src  = (j >= k) ? (j - k) : (j + N - k);
         pick = dense[src*CW +: CW];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       rotated[j*CW +: CW] <= '0;
         else if (turn_en) rotated[j*CW +: CW] <= pick;
      end
   end

   if (IW < 1) begin : g_bad_iw
      $error("tern_conv_rotator: index width must be at least 1");
   end
endmodule

// File: rtl/tern_conv_lane.sv
module tern_conv_lane #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          apply_en,
   input  logic          neg,
   input  logic [CW-1:0] operand,
   output logic [CW-1:0] acc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        acc <= '0;
      else if (clr)      acc <= '0;
      else if (apply_en) acc <= neg ? (acc - operand) : (acc + operand);
   end
endmodule

// File: rtl/tern_conv_mul.sv
module tern_conv_mul #(
   parameter int N = 31,
   parameter int D = 4,
   parameter int Q = 2048
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_en,
   input  logic [$clog2(N)-1:0] load_addr,
   input  logic [$clog2(Q)-1:0] load_data,
   input  logic                 start,
   input  logic [$clog2(N)-1:0] term_idx,
   input  logic                 term_neg,
   output logic                 term_take,
   output logic                 busy,
   output logic                 done,
   output logic [N*$clog2(Q)-1:0] result
);
   localparam int CW = $clog2(Q);
   localparam int IW = $clog2(N);

   if ((1 << CW) != Q) begin : g_bad_q
      $error("tern_conv_mul: Q must be a power of two");
   end
   if (N < 2) begin : g_bad_n
      $error("tern_conv_mul: N must be at least 2");
   end
   if (D < 1 || 2 * D > N) begin : g_bad_d
      $error("tern_conv_mul: D must satisfy 1 <= 2*D <= N");
   end

   logic clr, grab_en, turn_en, apply_en;
   logic [N*CW-1:0] dense_q;
   logic [N*CW-1:0] rot_q;
   logic [IW-1:0]   idx_q;
   logic            neg_q;

   tern_conv_ctrl #(.D(D)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .clr(clr),
      .grab_en(grab_en), .turn_en(turn_en), .apply_en(apply_en),
      .busy(busy), .done(done)
   );

   assign term_take = grab_en;

   for (genvar i = 0; i < N; i++) begin : g_dense
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dense_q[i*CW +: CW] <= '0;
         else if (load_en && !busy && load_addr == IW'(i))
            dense_q[i*CW +: CW] <= load_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         neg_q <= 1'b0;
      end else if (grab_en) begin
         idx_q <= term_idx;
         neg_q <= term_neg;
      end
   end

   tern_conv_rotator #(.N(N), .CW(CW)) i_rot (
      .clk(clk), .rst_n(rst_n), .turn_en(turn_en),
      .shift(idx_q), .dense(dense_q), .rotated(rot_q)
   );

   for (genvar j = 0; j < N; j++) begin : g_acc
      tern_conv_lane #(.CW(CW)) i_lane (
         .clk(clk), .rst_n(rst_n), .clr(clr), .apply_en(apply_en),
         .neg(neg_q), .operand(rot_q[j*CW +: CW]), .acc(result[j*CW +: CW])
      );
   end
endmodule

// File: rtl/tern_conv_mul_chk.sv
module tern_conv_mul_chk #(
   parameter int N  = 31,
   parameter int CW = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          term_take,
   input logic          apply_en,
   input logic [N*CW-1:0] result
);
   p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (result == '0) && busy);

   p_take_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      term_take |=> !term_take ##1 !term_take);

   p_take_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> term_take);

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));

   p_acc_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !apply_en) |=> $stable(result));
endmodule

bind tern_conv_mul tern_conv_mul_chk #(.N(N), .CW($clog2(Q))) i_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .term_take(term_take), .apply_en(apply_en), .result(result)
);

// File: tb/test_tern_conv_mul.sv
module test_tern_conv_mul;
   localparam int N  = 7;
   localparam int D  = 2;
   localparam int NT = 2 * D;
   localparam int CW = 11;
   localparam int IW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load_en = 1'b0;
   logic [IW-1:0] load_addr = '0;
   logic [CW-1:0] load_data = '0;
   logic start = 1'b0;
   logic [IW-1:0] term_idx = '0;
   logic term_neg = 1'b0;
   logic term_take, busy, done;
   logic [N*CW-1:0] result;

   int vectors = 0;
   int errors  = 0;
   int dense [N];
   int tidx [NT];
   int tneg [NT];
   int expv [N];

   always #10 clk = ~clk;

   tern_conv_mul #(.N(N), .D(D), .Q(2048)) i_tern_conv_mul (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
      .load_data(load_data), .start(start), .term_idx(term_idx),
      .term_neg(term_neg), .term_take(term_take), .busy(busy), .done(done),
      .result(result)
   );

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load_dense();
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         load_en = 1'b1; load_addr = IW'(i); load_data = CW'(dense[i]);
      end
      @(negedge clk);
      load_en = 1'b0;
   endtask

   task automatic model();
      for (int j = 0; j < N; j++) expv[j] = 0;
      for (int t = 0; t < NT; t++)
         for (int i = 0; i < N; i++) begin
            int p;
            p = (i + tidx[t]) % N;
            expv[p] = tneg[t] ? (expv[p] - dense[i]) & 2047 : (expv[p] + dense[i]) & 2047;
         end
   endtask

   task automatic check_result(input string req);
      int bad;
      int first;
      bad = 0; first = -1;
      for (int j = 0; j < N; j++)
         if (int'(result[j*CW +: CW]) != expv[j]) begin
            bad++;
            if (first < 0) first = j;
         end
      if (first < 0) check(req, 0, 0);
      else check({req, " coeff"}, int'(result[first*CW +: CW]), expv[first]);
   endtask

   // Runs one multiplication; returns cycles counted from the start edge.
   task automatic run(output int cycles, output int takes);
      int ptr;
      ptr = 0; takes = 0; cycles = 0;
      term_idx = IW'(tidx[0]); term_neg = tneg[0][0];
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cycles = 1;
      while (!done && cycles < 1000) begin
         if (term_take) begin
            takes++;
            @(negedge clk);
            ptr++;
            if (ptr < NT) begin term_idx = IW'(tidx[ptr]); term_neg = tneg[ptr][0]; end
         end else @(negedge clk);
         cycles++;
      end
   endtask

   task automatic t_reset();
      check("R2 reset busy", int'(busy), 0);
      check("R6 reset done", int'(done), 0);
      check("R3 reset take", int'(term_take), 0);
      check("R7 reset result", (result == '0) ? 0 : 1, 0);
   endtask

   task automatic t_mixed();
      int cyc, tk;
      dense = '{5, 100, 2000, 7, 0, 1234, 33};
      tidx = '{3, 5, 1, 6};
      tneg = '{0, 0, 1, 1};
      load_dense(); model(); run(cyc, tk);
      check_result("R4 R5 mixed");
      check("R6 latency", cyc, 6 * D + 1);
      check("R3 take count", tk, NT);
      @(negedge clk);
      check("R6 done one cycle", int'(done), 0);
      repeat (5) @(negedge clk);
      check_result("R7 hold after done");
   endtask

   task automatic t_edges();
      int cyc, tk;
      dense = '{1, 2, 3, 4, 5, 6, 7};
      tidx = '{0, 0, N - 1, 0};
      tneg = '{0, 0, 0, 1};
      load_dense(); model(); run(cyc, tk);
      check_result("R9 index 0 and N-1");
   endtask

   task automatic t_extreme();
      int cyc, tk;
      dense = '{2047, 2047, 2047, 2047, 2047, 2047, 2047};
      tidx = '{0, 2, 4, 6};
      tneg = '{0, 0, 0, 0};
      load_dense(); model(); run(cyc, tk);
      check_result("R8 wrap at 2047");
      check("R8 coeff0", int'(result[0 +: CW]), (4 * 2047) & 2047);
   endtask

   task automatic t_sign();
      int cyc, tk;
      dense = '{9, 0, 0, 0, 0, 0, 1};
      tidx = '{1, 4, 2, 0};
      tneg = '{1, 1, 1, 1};
      load_dense(); model(); run(cyc, tk);
      check_result("R5 sign bit governs");
   endtask

   task automatic t_ignore();
      int cyc, tk;
      dense = '{1, 1, 1, 1, 1, 1, 1};
      tidx = '{0, 0, 0, 0};
      tneg = '{0, 0, 0, 0};
      load_dense();
      // out-of-range address while idle must not disturb anything
      @(negedge clk); load_en = 1'b1; load_addr = IW'(N); load_data = 11'd500;
      @(negedge clk); load_en = 1'b0;
      term_idx = '0; term_neg = 1'b0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      // load and extra start while busy
      load_en = 1'b1; load_addr = '0; load_data = 11'd999;
      @(negedge clk); load_en = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!done) @(negedge clk);
      model();
      check_result("R7 start while busy ignored");
      // repeat: dense must be unchanged (R1)
      run(cyc, tk);
      check_result("R1 busy and out-of-range loads ignored");
      check("R2 clear then four ones", int'(result[3*CW +: CW]), 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_mixed();
      t_edges();
      t_extreme();
      t_sign();
      t_ignore();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule